// File: doc/BRIEF.md
# I2C EEPROM Burst Reader

This block is a single-master I2C controller that reads a run of bytes from a serial EEPROM. The EEPROM uses a 16-bit word address. A one-cycle command pulse carries a start address and a byte count. The block then runs the following sequence on the bus:

1. A START, then the device address with the write bit.
2. The word address as two bytes.
3. A repeated START, then the device address with the read bit.
4. A read phase, at the end of which it releases the bus with a STOP.

Each byte that arrives is presented for one cycle on a valid strobe. A done pulse closes every command.

SCL and SDA are open-drain lines. An enable output high means the block pulls that line low. The block reads the resolved line levels back on its two inputs. A divider input sets the bit rate. The block holds off until the bus is seen to be free, and it treats a missing acknowledge on any addressing byte as a failed transfer.

Top module: `eeprom_burst_reader`

## Requirements
- R1: A command with a byte count of zero produces done_o in the next cycle, with err_o low and no line ever pulled low.
- R2: After another master issues a START (SDA falling while SCL is high), a command neither pulls SCL nor SDA low until that master's STOP (SDA rising while SCL is high) has been seen.
- R3: During a transfer, consecutive rising edges of SCL are 4 × (div_i + 1) clock cycles apart.
- R4: The first byte after START is 0xA0 (device 0x50, write). It is followed by the high byte of addr_i, then the low byte. Bytes are sent MSB first, and the slave's acknowledge is sampled after each byte.
- R5: After the low address byte, a repeated START follows with no STOP before it, and the next byte sent is 0xA1 (device 0x50, read).
- R6: Received bytes are assembled MSB first. Each one appears on data_o with valid_o high for exactly one cycle. Exactly count_i bytes are delivered, in ascending address order.
- R7: The master drives SDA low (ACK) in the acknowledge slot of every received byte except the last, where it leaves SDA high (NACK). A count of one gives a NACK on the first byte.
- R8: After the final byte's NACK, the block generates exactly one STOP. It then pulses done_o with err_o low, and both lines are released.
- R9: If the slave leaves SDA high in the acknowledge slot of any addressing byte, the block sends no further bytes. It generates a STOP and raises err_o in the same cycle as done_o, and delivers no data.
- R10: SDA changes while SCL is released only to form the START and STOP conditions. A normal burst shows exactly two STARTs and one STOP on the bus.
- R11: Out of reset and between commands, both line enables are low and valid_o and done_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle command pulse, accepted when idle |
| addr_i | input | 16 | EEPROM word address of the first byte |
| count_i | input | CNT_W | Number of bytes to read |
| div_i | input | DIV_W | Divider; one quarter of an SCL period is div_i + 1 clocks |
| scl_i | input | 1 | Resolved SCL line level |
| sda_i | input | 1 | Resolved SDA line level |
| scl_oe_o | output | 1 | Pull SCL low when high |
| sda_oe_o | output | 1 | Pull SDA low when high |
| data_o | output | 8 | Received byte |
| valid_o | output | 1 | data_o holds a new byte this cycle |
| done_o | output | 1 | Command finished (one cycle) |
| err_o | output | 1 | Addressing byte not acknowledged; high with done_o |

## Verification
With a count of one, the first received byte is also the last. The byte-complete event (valid strobe and remaining count reaching zero) and the decision to NACK that byte's acknowledge slot therefore fall together. The bench provokes this with a one-byte read at the top of the address space, using a slower divider. It judges the outcome at the bus: the slave model records a released SDA in the single acknowledge slot, one delivered byte, and one STOP. In the four-byte burst, the same decision must instead give three ACKs and then a NACK.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT,
        S_START,
        S_TX,
        S_RX,
        S_STOP
    } rd_state_e;

    localparam logic [7:0] DEV_WRITE = 8'hA0;
    localparam logic [7:0] DEV_READ  = 8'hA1;

    // byte sent in the addressing phase, selected by slot number
    function automatic logic [7:0] addr_phase_byte(input logic [1:0] slot, input logic [15:0] word);
        case (slot)
            2'd0:    return DEV_WRITE;
            2'd1:    return word[15:8];
            2'd2:    return word[7:0];
            default: return DEV_READ;
        endcase
    endfunction

endpackage

// File: rtl/i2c_quarter_tick.sv
module i2c_quarter_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } tick_reg_t;

    tick_reg_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (!run_i)              r_d.cnt = '0;
        else if (r_q.cnt == div_i) r_d.cnt = '0;
        else                     r_d.cnt = r_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign tick_o = run_i && (r_q.cnt == div_i);

endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic free_o
);
    typedef struct packed {
        logic scl;
        logic sda;
        logic busy;
    } watch_reg_t;

    watch_reg_t r_q, r_d;

    always_comb begin
        r_d     = r_q;
        r_d.scl = scl_i;
        r_d.sda = sda_i;
        if (r_q.scl && scl_i && r_q.sda && !sda_i)      r_d.busy = 1'b1;
        else if (r_q.scl && scl_i && !r_q.sda && sda_i) r_d.busy = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{scl: 1'b1, sda: 1'b1, busy: 1'b0};
        else        r_q <= r_d;
    end

    assign free_o = !r_q.busy && scl_i && sda_i;

endmodule

// File: rtl/eeprom_burst_reader.sv
module eeprom_burst_reader
    import eeprom_rd_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [15:0]      addr_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             scl_oe_o,
    output logic             sda_oe_o,
    output logic [7:0]       data_o,
    output logic             valid_o,
    output logic             done_o,
    output logic             err_o
);
    localparam logic [3:0] ACK_SLOT = 4'd8;

    typedef struct packed {
        rd_state_e        st;
        logic [1:0]       ph;
        logic [3:0]       bitn;
        logic [1:0]       slot;
        logic [7:0]       sh;
        logic [CNT_W-1:0] rem;
        logic [15:0]      word;
        logic             fail;
        logic             scl_oe;
        logic             sda_oe;
        logic [7:0]       data;
        logic             valid;
        logic             done;
        logic             err;
    } rd_reg_t;

    rd_reg_t r_q, r_d;
    logic    tick;
    logic    bus_free;
    logic    run;

    assign run = (r_q.st == S_START) || (r_q.st == S_TX) ||
                 (r_q.st == S_RX)    || (r_q.st == S_STOP);

    i2c_quarter_tick #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .div_i  (div_i),
        .tick_o (tick)
    );

    i2c_bus_watch u_watch (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_i),
        .sda_i  (sda_i),
        .free_o (bus_free)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        r_d.done  = 1'b0;
        r_d.err   = 1'b0;
        unique case (r_q.st)
            S_IDLE: begin
                if (start_i) begin
                    if (count_i == '0) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st   = S_WAIT;
                        r_d.word = addr_i;
                        r_d.rem  = count_i;
                        r_d.slot = 2'd0;
                        r_d.fail = 1'b0;
                    end
                end
            end
            S_WAIT: begin
                if (bus_free) begin
                    r_d.st     = S_START;
                    r_d.ph     = 2'd0;
                    r_d.scl_oe = 1'b1;
                end
            end
            S_START: begin
                if (tick) begin
                    r_d.ph = r_q.ph + 2'd1;
                    case (r_q.ph)
                        2'd0: r_d.sda_oe = 1'b0;
                        2'd1: r_d.scl_oe = 1'b0;
                        2'd2: r_d.sda_oe = 1'b1;
                        default: begin
                            r_d.st     = S_TX;
                            r_d.bitn   = '0;
                            r_d.sh     = addr_phase_byte(r_q.slot, r_q.word);
                            r_d.scl_oe = 1'b1;
                        end
                    endcase
                end
            end
            S_TX: begin
                if (tick) begin
                    r_d.ph = r_q.ph + 2'd1;
                    case (r_q.ph)
                        2'd0: r_d.sda_oe = (r_q.bitn == ACK_SLOT) ? 1'b0 : !r_q.sh[7];
                        2'd1: r_d.scl_oe = 1'b0;
                        2'd2: ;
                        default: begin
                            r_d.scl_oe = 1'b1;
                            if (r_q.bitn != ACK_SLOT) begin
                                r_d.sh   = {r_q.sh[6:0], 1'b0};
                                r_d.bitn = r_q.bitn + 4'd1;
                            end else if (sda_i) begin
                                r_d.fail = 1'b1;
                                r_d.st   = S_STOP;
                            end else if (r_q.slot == 2'd2) begin
                                r_d.slot = 2'd3;
                                r_d.st   = S_START;
                            end else if (r_q.slot == 2'd3) begin
                                r_d.st   = S_RX;
                                r_d.bitn = '0;
                            end else begin
                                r_d.slot = r_q.slot + 2'd1;
                                r_d.sh   = addr_phase_byte(r_q.slot + 2'd1, r_q.word);
                                r_d.bitn = '0;
                            end
                        end
                    endcase
                end
            end
            S_RX: begin
                if (tick) begin
                    r_d.ph = r_q.ph + 2'd1;
                    case (r_q.ph)
                        2'd0: r_d.sda_oe = (r_q.bitn == ACK_SLOT) ? (r_q.rem != '0) : 1'b0;
                        2'd1: r_d.scl_oe = 1'b0;
                        2'd2: ;
                        default: begin
                            r_d.scl_oe = 1'b1;
                            if (r_q.bitn != ACK_SLOT) begin
                                r_d.sh   = {r_q.sh[6:0], sda_i};
                                r_d.bitn = r_q.bitn + 4'd1;
                                if (r_q.bitn == 4'd7) begin
                                    r_d.valid = 1'b1;
                                    r_d.data  = {r_q.sh[6:0], sda_i};
                                    r_d.rem   = r_q.rem - 1'b1;
                                end
                            end else begin
                                r_d.bitn = '0;
                                if (r_q.rem == '0) r_d.st = S_STOP;
                            end
                        end
                    endcase
                end
            end
            S_STOP: begin
                if (tick) begin
                    r_d.ph = r_q.ph + 2'd1;
                    case (r_q.ph)
                        2'd0: r_d.sda_oe = 1'b1;
                        2'd1: r_d.scl_oe = 1'b0;
                        2'd2: r_d.sda_oe = 1'b0;
                        default: begin
                            r_d.st   = S_IDLE;
                            r_d.done = 1'b1;
                            r_d.err  = r_q.fail;
                        end
                    endcase
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: S_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign scl_oe_o = r_q.scl_oe;
    assign sda_oe_o = r_q.sda_oe;
    assign data_o   = r_q.data;
    assign valid_o  = r_q.valid;
    assign done_o   = r_q.done;
    assign err_o    = r_q.err;

    // R1
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_IDLE && start_i && count_i == '0) |=> (done_o && !err_o && !scl_oe_o));

    // R2
    wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_WAIT) |-> (!scl_oe_o && !sda_oe_o));

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R9
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);

    // R10
    sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe_o && !$past(scl_oe_o) && (sda_oe_o != $past(sda_oe_o)))
            |-> ($past(r_q.st) == S_START || $past(r_q.st) == S_STOP));

    // R11
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_IDLE) |-> (!scl_oe_o && !sda_oe_o && !valid_o));

endmodule

// File: tb/sim_eeprom_burst_reader.sv
module sim_eeprom_burst_reader;
    localparam int CNT_W = 8;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [15:0]      addr_i = '0;
    logic [CNT_W-1:0] count_i = '0;
    logic [DIV_W-1:0] div_i = '0;
    logic             scl_oe_o, sda_oe_o, valid_o, done_o, err_o;
    logic [7:0]       data_o;
    logic             ext_scl = 1'b0, ext_sda = 1'b0, slv_sda = 1'b0;
    wire              scl = !(scl_oe_o | ext_scl);
    wire              sda = !(sda_oe_o | ext_sda | slv_sda);

    always #4 clk = !clk;

    eeprom_burst_reader #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .count_i(count_i), .div_i(div_i), .scl_i(scl), .sda_i(sda),
        .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o), .data_o(data_o),
        .valid_o(valid_o), .done_o(done_o), .err_o(err_o)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input logic ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] memv(input logic [15:0] a);
        logic [15:0] t;
        t = a * 16'd13 + 16'd7;
        return t[7:0] ^ a[15:8];
    endfunction

    // ---------------- slave model and bus recorder ----------------
    int cyc = 0;
    int n_start, n_stop, stops_at_rs, ntx, nmack, nrise, nfall, nrx, dbl_valid, nack_idx;
    logic [7:0] txb [8];
    logic       mack [16];
    int         rise_t [8];
    logic [7:0] rxd [16];
    logic scl_p = 1'b1, sda_p = 1'b1;
    int   bc, bidx;
    logic rd, rd_pend, last_mack;
    logic [7:0]  sh, dat;
    logic [15:0] ptr;

    task automatic clear_rec();
        n_start = 0; n_stop = 0; stops_at_rs = -1; ntx = 0; nmack = 0;
        nrise = 0; nfall = 0; nrx = 0; dbl_valid = 0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (scl && scl_p && sda_p && !sda) begin
            n_start++;
            if (n_start == 2) stops_at_rs = n_stop;
            bc = 0; bidx = 0; rd = 1'b0; rd_pend = 1'b0;
            slv_sda <= 1'b0;
        end else if (scl && scl_p && !sda_p && sda) begin
            n_stop++;
            bc = 0; rd = 1'b0; rd_pend = 1'b0;
            slv_sda <= 1'b0;
        end else if (scl && !scl_p) begin
            if (nrise < 8) rise_t[nrise] = cyc;
            nrise++;
            if (bc < 8) sh = {sh[6:0], sda};
            if (bc == 8 && rd) begin
                last_mack = sda;
                if (nmack < 16) mack[nmack] = sda;
                nmack++;
            end
            bc++;
        end else if (!scl && scl_p) begin
            nfall++;
            if (bc == 8 && !rd) begin
                if (ntx < 8) txb[ntx] = sh;
                ntx++;
                if (bidx == 1) ptr[15:8] = sh;
                if (bidx == 2) ptr[7:0] = sh;
                if (bidx == 0 && sh == 8'hA1 && nack_idx != 0) rd_pend = 1'b1;
                slv_sda <= (bidx != nack_idx);
            end else if (bc == 8 && rd) begin
                slv_sda <= 1'b0;
                ptr = ptr + 16'd1;
            end else if (bc == 9) begin
                bc = 0;
                bidx++;
                if (rd_pend || (rd && !last_mack)) begin
                    rd = 1'b1; rd_pend = 1'b0;
                    dat = memv(ptr);
                    slv_sda <= !dat[7];
                end else begin
                    rd = 1'b0;
                    slv_sda <= 1'b0;
                end
            end else if (rd && bc >= 1 && bc <= 7) begin
                slv_sda <= !dat[7 - bc];
            end
        end
        scl_p <= scl;
        sda_p <= sda;
    end

    logic valid_p = 1'b0;
    always @(negedge clk) begin
        if (valid_o) begin
            if (nrx < 16) rxd[nrx] = data_o;
            nrx++;
            if (valid_p) dbl_valid++;
        end
        valid_p = valid_o;
    end

    // ---------------- helpers ----------------
    task automatic issue(input logic [15:0] a, input int n, input int dv);
        @(negedge clk);
        addr_i = a; count_i = CNT_W'(n); div_i = DIV_W'(dv); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(output logic got_err, output logic seen);
        seen = 1'b0; got_err = 1'b0;
        for (int i = 0; i < 40000 && !seen; i++) begin
            if (done_o) begin seen = 1'b1; got_err = err_o; end
            else @(negedge clk);
        end
        @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(!scl_oe_o && !sda_oe_o, "R11", "line enables after reset", {scl_oe_o, sda_oe_o}, 0);
        chk(!valid_o && !done_o, "R11", "valid/done after reset", {valid_o, done_o}, 0);
    endtask

    task automatic t_zero();
        clear_rec();
        @(negedge clk);
        addr_i = 16'h0100; count_i = '0; div_i = 8'd1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(done_o && !err_o, "R1", "done one cycle after zero count", {done_o, err_o}, 2);
        repeat (60) @(negedge clk);
        chk(nfall == 0 && n_start == 0, "R1", "no bus activity for zero count", nfall, 0);
    endtask

    task automatic t_burst();
        logic e, s;
        clear_rec();
        nack_idx = 99;
        issue(16'h1234, 4, 1);
        wait_done(e, s);
        chk(s && !e, "R8", "done without error", {s, e}, 2);
        chk(ntx == 4, "R4", "addressing bytes sent", ntx, 4);
        chk(txb[0] == 8'hA0, "R4", "device write byte", txb[0], 8'hA0);
        chk(txb[1] == 8'h12 && txb[2] == 8'h34, "R4", "word address high/low", {txb[1], txb[2]}, 16'h1234);
        chk(txb[3] == 8'hA1, "R5", "device read byte", txb[3], 8'hA1);
        chk(stops_at_rs == 0, "R5", "no stop before repeated start", stops_at_rs, 0);
        chk(n_start == 2 && n_stop == 1, "R10", "start/stop conditions on bus", n_start * 16 + n_stop, 33);
        chk(nrx == 4 && dbl_valid == 0, "R6", "bytes delivered / strobe width", nrx * 16 + dbl_valid, 64);
        for (int i = 0; i < 4; i++)
            chk(rxd[i] == memv(16'h1234 + 16'(i)), "R6", "received data", rxd[i], memv(16'h1234 + 16'(i)));
        chk(nmack == 4 && mack[0] == 0 && mack[1] == 0 && mack[2] == 0 && mack[3] == 1,
            "R7", "ack pattern", {mack[0], mack[1], mack[2], mack[3]}, 4'b0001);
        chk(rise_t[3] - rise_t[2] == 8, "R3", "SCL period div=1", rise_t[3] - rise_t[2], 8);
        chk(!scl_oe_o && !sda_oe_o, "R8", "lines released after stop", {scl_oe_o, sda_oe_o}, 0);
    endtask

    task automatic t_single();
        logic e, s;
        clear_rec();
        nack_idx = 99;
        issue(16'hFFFF, 1, 3);
        wait_done(e, s);
        chk(s && !e, "R8", "single read done", {s, e}, 2);
        chk(nmack == 1 && mack[0] == 1, "R7", "NACK on only byte", nmack * 2 + int'(mack[0]), 3);
        chk(nrx == 1 && rxd[0] == memv(16'hFFFF), "R6", "single byte data", rxd[0], memv(16'hFFFF));
        chk(n_stop == 1, "R8", "one stop", n_stop, 1);
        chk(rise_t[3] - rise_t[2] == 16, "R3", "SCL period div=3", rise_t[3] - rise_t[2], 16);
    endtask

    task automatic t_nack(input int which);
        logic e, s;
        clear_rec();
        nack_idx = which;
        issue(16'h0A0B, 3, 0);
        wait_done(e, s);
        chk(s && e, "R9", "error with done", {s, e}, 3);
        chk(ntx == which + 1, "R9", "bytes sent before abort", ntx, which + 1);
        chk(n_stop == 1 && nrx == 0 && n_start == 1, "R9", "stop, no data", n_stop * 16 + nrx, 16);
        nack_idx = 99;
    endtask

    task automatic t_busy();
        logic e, s;
        clear_rec();
        nack_idx = 99;
        @(negedge clk); ext_sda = 1'b1;
        repeat (4) @(negedge clk);
        issue(16'h0040, 2, 1);
        clear_rec();
        repeat (300) @(negedge clk);
        chk(nfall == 0 && !sda_oe_o, "R2", "quiet while bus held", nfall, 0);
        ext_sda = 1'b0;
        wait_done(e, s);
        chk(s && !e && nrx == 2, "R2", "transfer after release", nrx, 2);
        chk(rxd[1] == memv(16'h0041), "R6", "data after wait", rxd[1], memv(16'h0041));
    endtask

    initial begin
        logic to;
        to = 1'b0;
        nack_idx = 99;
        clear_rec();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_zero();
        t_burst();
        t_single();
        t_nack(1);
        t_nack(0);
        t_busy();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule